// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Front End

This block is the digital front end of a four-channel, 12-bit converter whose registers are loaded in two stages. A host drives a three-wire serial port plus load and clear pins. The block runs on a fast system clock and passes every pin through a two-flop synchronizer. It recovers the serial clock edges and shifts a 16-bit frame into a holding register. On a load strobe it copies the frame's 12-bit code into one of four channel registers.

Shifting, loading and clearing are separate actions. A frame sits in the holding register until the load pin falls. The load then updates only the channel that the frame addresses. A clear forces all four channel registers to zero scale or to midscale, as a select pin chooses. The clear leaves the holding register untouched. Once the clear is released, the cleared value stays until the next load. A one-hot flag shows which channel was written last. The system clock must run at least four times faster than the serial clock.

Top module: `qdac_frontend`

## Requirements
- R1: After reset, all four channel codes are 0x000, the holding register is 0x0000, and the last-loaded flag is 0000.
- R2: A frame is 16 bits, shifted most significant bit first. Holding-register bits 15:14 are the address, bits 13:12 are ignored, and bits 11:0 are the code.
- R3: Address 00 selects channel 0 (dacCodes[11:0]), 01 selects channel 1 (dacCodes[23:12]), 10 selects channel 2 (dacCodes[35:24]) and 11 selects channel 3 (dacCodes[47:36]).
- R4: A load changes only the addressed channel. The other three channel codes keep their values.
- R5: A bit is shifted in only on a rising edge of the OR of csN and sclkIn, which can occur only while csN is low. Serial clock activity while csN is high leaves the holding register unchanged.
- R6: If csN rises while sclkIn is low, the OR of the two rises, and the current sdinIn value is shifted in as an extra bit.
- R7: A falling edge of ldacN performs a load at any level of csN. A steady low or a rising edge of ldacN performs no load.
- R8: While clrN is low, all four codes are forced to 0x000 if clrSel is 0, or to 0x800 if clrSel is 1. The last-loaded flag does not change.
- R9: A clear does not alter the holding register. After clrN returns high, the codes keep the clear value until the next ldacN falling edge, which loads from the held frame.
- R10: If clrN is low in the cycle where an ldacN falling edge is detected, the clear takes effect and the load is dropped.
- R11: After a load, the last-loaded flag is one-hot, with bit i set for channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock pin, asynchronous |
| sdinIn | input | 1 | Serial data pin, asynchronous |
| csN | input | 1 | Active-low select pin |
| ldacN | input | 1 | Active-low load pin; loads on its falling edge |
| clrN | input | 1 | Active-low level clear |
| clrSel | input | 1 | Clear target: 0 gives zero scale, 1 gives midscale |
| dacCodes | output | 48 | Four 12-bit channel codes, channel 0 in the low bits |
| lastLoaded | output | 4 | One-hot flag of the channel loaded most recently |

## Verification
The bench sweeps every address with several codes and pad patterns, and keeps an arithmetic model of all four channels. This model would catch a swapped decode, a wrong field slice, or a load that also writes the other channels. It toggles the serial clock with select high; a design that ignores select would pick up those bits and load the wrong channel. It ends a frame by raising select while the serial clock is low; a design that clocks only on the serial clock would miss the sixteenth bit and load a shifted code. Clear tests cover both targets, release followed by reload from the held frame, and clear overlapping a load edge. A design that erased the holding register on clear, or let the load win, would show wrong codes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
    logic clearEn;
    logic clearMid;
  } qdac_strobes_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkIn,
  input  logic          sdinIn,
  input  logic          csN,
  input  logic          ldacN,
  input  logic          clrN,
  input  logic          clrSel,
  output qdac_strobes_t strobes
);
  localparam int NIN = 6;
  localparam int B_SCLK = 0;
  localparam int B_SDIN = 1;
  localparam int B_CS   = 2;
  localparam int B_LDAC = 3;
  localparam int B_CLR  = 4;
  localparam int B_SEL  = 5;
  // idle levels: clrSel 0, clrN 1, ldacN 1, csN 1, sdin 0, sclk 1
  localparam logic [NIN-1:0] IDLE = 6'b011101;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] stage [SYNC_STAGES];
  logic [NIN-1:0] syncd;
  logic shiftClk, shiftClkPrev, ldacPrev;

  assign rawIn = {clrSel, clrN, ldacN, csN, sdinIn, sclkIn};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= IDLE;
      else if (s == 0) stage[s] <= rawIn;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign syncd    = stage[SYNC_STAGES-1];
  assign shiftClk = syncd[B_SCLK] | syncd[B_CS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftClkPrev <= 1'b1;
      ldacPrev     <= 1'b1;
    end else begin
      shiftClkPrev <= shiftClk;
      ldacPrev     <= syncd[B_LDAC];
    end
  end

  always_comb begin
    strobes.shiftEn  = shiftClk & ~shiftClkPrev;
    strobes.shiftBit = syncd[B_SDIN];
    strobes.loadEn   = ~syncd[B_LDAC] & ldacPrev;
    strobes.clearEn  = ~syncd[B_CLR];
    strobes.clearMid = syncd[B_SEL];
  end

  // R5
  cs_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncd[B_CS] && $past(syncd[B_CS])) |-> !strobes.shiftEn);
  // R7
  load_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> !strobes.loadEn);
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int CH_COUNT = 4,
  parameter int CODE_W   = 12,
  parameter int PAD_W    = 2,
  localparam int ADDR_W  = $clog2(CH_COUNT),
  localparam int FRAME_W = ADDR_W + PAD_W + CODE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  qdac_strobes_t              strobes,
  output logic [CH_COUNT*CODE_W-1:0] codes,
  output logic [CH_COUNT-1:0]        lastLoaded
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

  logic [FRAME_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  addr;
  logic [CODE_W-1:0]  code;
  logic [CODE_W-1:0]  clearValue;
  logic [CH_COUNT-1:0] addrHot;

  assign addr       = shiftReg[FRAME_W-1 -: ADDR_W];
  assign code       = shiftReg[CODE_W-1:0];
  assign clearValue = strobes.clearMid ? MID : '0;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], strobes.shiftBit};
  end

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    assign addrHot[c] = (addr == ADDR_W'(c));
    always_ff @(posedge clk) begin
      if (!rstN) codes[c*CODE_W +: CODE_W] <= '0;
      else if (strobes.clearEn) codes[c*CODE_W +: CODE_W] <= clearValue;
      else if (strobes.loadEn && addrHot[c]) codes[c*CODE_W +: CODE_W] <= code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastLoaded <= '0;
    else if (strobes.loadEn && !strobes.clearEn) lastLoaded <= addrHot;
  end

  // R8
  clear_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearEn |=> codes == ($past(strobes.clearMid) ? {CH_COUNT{MID}} : '0));
  // R9
  shift_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn |=> $stable(shiftReg));
  // R4
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadEn && !strobes.clearEn) |=> $stable(codes));
  // R11
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && !strobes.clearEn) |=> $countones(lastLoaded) == 1);
  // R10
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearEn |=> $stable(lastLoaded));
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
  import qdac_pkg::*;
#(
  parameter int CH_COUNT    = 4,
  parameter int CODE_W      = 12,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclkIn,
  input  logic                       sdinIn,
  input  logic                       csN,
  input  logic                       ldacN,
  input  logic                       clrN,
  input  logic                       clrSel,
  output logic [CH_COUNT*CODE_W-1:0] dacCodes,
  output logic [CH_COUNT-1:0]        lastLoaded
);
  qdac_strobes_t strobes;

  qdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdinIn(sdinIn), .csN(csN),
    .ldacN(ldacN), .clrN(clrN), .clrSel(clrSel), .strobes(strobes)
  );

  qdac_datapath #(.CH_COUNT(CH_COUNT), .CODE_W(CODE_W), .PAD_W(PAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .codes(dacCodes), .lastLoaded(lastLoaded)
  );
endmodule

// File: tb/qdac_frontend_test.sv
module qdac_frontend_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, sclkIn, sdinIn, csN, ldacN, clrN, clrSel;
  logic [47:0] dacCodes;
  logic [3:0]  lastLoaded;
  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  logic [11:0] expCode [4];
  logic [3:0]  expFlag;

  qdac_frontend uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdinIn(sdinIn), .csN(csN),
    .ldacN(ldacN), .clrN(clrN), .clrSel(clrSel),
    .dacCodes(dacCodes), .lastLoaded(lastLoaded)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(dacCodes[c*12 +: 12]), 32'(expCode[c]));
    chk(req, 32'(lastLoaded), 32'(expFlag));
  endtask

  task automatic shiftBits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) begin
      sclkIn = 1'b0; sdinIn = w[i]; waitClk(4);
      sclkIn = 1'b1; waitClk(4);
    end
  endtask

  task automatic sendFrame(input logic [15:0] w);
    csN = 1'b0; waitClk(4);
    shiftBits(w, 16);
    csN = 1'b1; waitClk(4);
  endtask

  task automatic pulseLdac();
    ldacN = 1'b0; waitClk(6);
    ldacN = 1'b1; waitClk(6);
  endtask

  task automatic loadModel(input logic [15:0] w);
    expCode[w[15:14]] = w[11:0];
    expFlag = 4'b0001 << w[15:14];
  endtask

  initial begin
    logic [15:0] w;
    logic [15:0] held;
    rstN = 1'b0; sclkIn = 1'b1; sdinIn = 1'b0; csN = 1'b1;
    ldacN = 1'b1; clrN = 1'b1; clrSel = 1'b0;
    for (int c = 0; c < 4; c++) expCode[c] = 12'h000;
    expFlag = 4'b0000;
    waitClk(5);
    rstN = 1'b1; waitClk(3);
    chkAll("R1 reset");
    // R1 holding register reset to zero: a bare load writes 0 to channel 0
    pulseLdac();
    loadModel(16'h0000);
    chkAll("R1 held word zero");

    // R2 R3 R4 R11 sweep every address with codes and pad patterns
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 6; k++) begin
        logic [11:0] d;
        d = 12'((a * 273 + k * 695 + (k == 5 ? 4095 : 0)) & 12'hFFF);
        if (k == 0) d = 12'h000;
        if (k == 1) d = 12'hFFF;
        w = {2'(a), 2'(k), d};
        sendFrame(w);
        chkAll("R4 no change before load");
        pulseLdac();
        loadModel(w);
        chkAll("R2 R3 R11 load sweep");
      end
    end

    // R5 serial clock with select high is ignored
    w = {2'b01, 2'b00, 12'h3C5};
    sendFrame(w); pulseLdac(); loadModel(w);
    for (int i = 0; i < 16; i++) begin
      sclkIn = 1'b0; sdinIn = i[0]; waitClk(4);
      sclkIn = 1'b1; waitClk(4);
    end
    pulseLdac();
    chkAll("R5 select high ignores clock");

    // R6 select rising while serial clock low shifts the last bit
    w = {2'b10, 2'b11, 12'h9A7};
    csN = 1'b0; waitClk(4);
    shiftBits(w, 15);
    sclkIn = 1'b0; sdinIn = w[0]; waitClk(4);
    csN = 1'b1; waitClk(4);
    sclkIn = 1'b1; waitClk(4);
    pulseLdac(); loadModel(w);
    chkAll("R6 extra edge from select");

    // R7 load with select held low, and steady-low load pin
    w = {2'b11, 2'b01, 12'h5E1};
    sendFrame(w);
    csN = 1'b0; waitClk(2);
    ldacN = 1'b0; waitClk(6);
    loadModel(w);
    chkAll("R7 load with select low");
    waitClk(10);
    ldacN = 1'b1; waitClk(6);
    csN = 1'b1; waitClk(4);
    chkAll("R7 no load on rising edge");
    held = w;

    // R8 clear to zero, flag unchanged
    clrSel = 1'b0; clrN = 1'b0; waitClk(6);
    for (int c = 0; c < 4; c++) expCode[c] = 12'h000;
    chkAll("R8 clear zero");
    clrN = 1'b1; waitClk(6);
    chkAll("R9 clear value held after release");
    pulseLdac(); loadModel(held);
    chkAll("R9 reload from held word");

    // R8 clear to midscale
    clrSel = 1'b1; clrN = 1'b0; waitClk(6);
    for (int c = 0; c < 4; c++) expCode[c] = 12'h800;
    chkAll("R8 clear midscale");
    clrN = 1'b1; waitClk(6);
    // R9 new frame after clear
    w = {2'b00, 2'b10, 12'h6B2};
    sendFrame(w);
    chkAll("R9 shift does not disturb cleared codes");
    pulseLdac(); loadModel(w);
    chkAll("R9 load new word after clear");

    // R10 clear and load edge together
    clrSel = 1'b0;
    clrN = 1'b0; ldacN = 1'b0; waitClk(6);
    for (int c = 0; c < 4; c++) expCode[c] = 12'h000;
    chkAll("R10 clear wins");
    clrN = 1'b1; waitClk(6);
    ldacN = 1'b1; waitClk(6);
    chkAll("R10 load dropped");
    pulseLdac(); loadModel(w);
    chkAll("R10 later load works");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      runCnt++; failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end
endmodule